// File: doc/BRIEF.md
# Dual-Channel DAC Serial Register Controller

This block is the digital register front end of a two-channel 12-bit converter. A host writes 24-bit frames over a three-wire serial link (active-low frame select, serial clock, serial data). Each completed frame carries a command, a channel address and a 12-bit code. Each channel holds a staged input register and a live DAC register, so new codes can be queued and then applied to both channels in the same cycle by an active-low load strobe. The block drives out the two live codes and a power-down flag for each channel.

All serial, load and clear inputs are sampled by the system clock `clk_i`, which must run well above the serial clock. Edges are found by comparing each input with its value one cycle earlier. A falling edge on the clear input zeroes both register levels of both channels and cancels any frame in progress. While clear stays low, the load strobe has no effect. Load requests are only acted on for channels whose input register has been written since its last transfer. Clear empties these pending flags, so a load after a clear moves nothing until a complete write has staged new data.

Top module: `dac_ctrl`

## Requirements
- R1: After reset both DAC codes read 0 and both power-down flags read 0.
- R2: Frame bits are shifted MSB first on each falling edge of `sclk_i` while `fs_ni` is low. The 24th falling edge completes the frame. Frame bits 21:19 hold the command, bits 18:16 the address (0 = channel A, 1 = channel B, 7 = both; A is the low 12 bits of `dac_code_o`) and bits 15:4 the 12-bit code. Command 3 writes the code to both registers of the addressed channels.
- R3: If `fs_ni` goes high before the 24th falling edge, the frame changes nothing, and the next frame starts again from bit 23.
- R4: Command 0 writes only the input register of the addressed channels. The DAC code does not change while `load_ni` is high.
- R5: While `load_ni` is low, each channel with a pending input write copies its input register to its DAC register. If `load_ni` is held low, DAC codes follow each completed command-0 write.
- R6: Command 1 copies the input register to the DAC register for the addressed channels. Command 2 writes the addressed input registers and then updates the DAC registers of both channels.
- R7: Command 4 sets the power-down mode of each channel. Code bits 1:0 (frame bits 5:4) set the mode of channel A and code bits 3:2 (frame bits 7:6) set the mode of channel B. A channel's flag is 1 when its mode is nonzero. DAC codes do not change.
- R8: Command 5 zeroes all input and DAC registers and clears both power-down flags.
- R9: A falling edge on `clr_ni` zeroes all input and DAC registers and drops pending writes. Power-down flags are kept. A load after the clear with no new write leaves the codes at 0.
- R10: While `clr_ni` is low, the load strobe has no effect. Data staged during that time is applied by a load after `clr_ni` returns high.
- R11: A clear falling edge during a frame aborts that frame. The rest of its clock edges are ignored until `fs_ni` goes high.
- R12: Falling edges after the 24th in a frame are ignored. Addresses 2 to 6 select no channel. Commands 6 and 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock; samples all other inputs |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock; idles high, data is taken on its falling edge |
| fs_ni | input | 1 | Active-low frame select |
| sdi_i | input | 1 | Serial data, MSB first |
| load_ni | input | 1 | Active-low load strobe |
| clr_ni | input | 1 | Active-low clear; its falling edge acts |
| dac_code_o | output | 24 | Live DAC codes, channel A in bits 11:0, channel B in bits 23:12 |
| pd_o | output | 2 | Power-down flag per channel, bit 0 for channel A |

## Verification
The hardest case to reach is a clear edge that arrives in the middle of a frame. The bench shifts twelve bits, pulses `clr_ni`, and then sends the remaining twelve bits. It checks that the channel stays at zero and that the following frame decodes cleanly. A second difficult case is data staged while clear is low. The bench completes a write while clear is held low, shows that a load pulse has no effect, then releases clear and shows that the same load now applies the data. Frame-select release after 20 bits and frames padded to 28 clock edges cover the bit counter's reset and lock.

// File: rtl/dac_pkg.sv
package dac_pkg;
  localparam int FRAME_W = 24;
  localparam int CODE_W  = 12;
  localparam int NCH     = 2;
  localparam int CMD_MSB = 21;
  localparam int ADR_MSB = 18;
  localparam int CODE_LSB = 4;

  typedef enum logic [2:0] {
    CMD_WR_IN      = 3'd0,
    CMD_UPD        = 3'd1,
    CMD_WR_UPD_ALL = 3'd2,
    CMD_WR_UPD     = 3'd3,
    CMD_PWR_DN     = 3'd4,
    CMD_SRST       = 3'd5
  } cmd_e;

  localparam logic [2:0] ADDR_ALL = 3'd7;
endpackage

// File: rtl/dac_serial_rx.sv
module dac_serial_rx #(
  parameter int FRAME_W = 24
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sclk_i,
  input  logic               fs_ni,
  input  logic               sdi_i,
  input  logic               abort_i,
  output logic               vld_o,
  output logic [FRAME_W-1:0] word_o
);
  localparam int CNT_W = $clog2(FRAME_W + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

  logic             sclk_q;
  logic             lock_q;
  logic [CNT_W-1:0] cnt_q;
  logic             fall;

  assign fall = sclk_q & ~sclk_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q <= 1'b1;
      lock_q <= 1'b0;
      cnt_q  <= '0;
      word_o <= '0;
      vld_o  <= 1'b0;
    end else begin
      sclk_q <= sclk_i;
      vld_o  <= 1'b0;
      if (fs_ni) begin
        cnt_q  <= '0;
        lock_q <= 1'b0;
      end else if (abort_i) begin
        cnt_q  <= '0;
        lock_q <= 1'b1;   // rest of this frame is dropped
      end else if (fall && !lock_q) begin
        word_o <= {word_o[FRAME_W-2:0], sdi_i};
        if (cnt_q == LAST) begin
          vld_o  <= 1'b1;
          lock_q <= 1'b1;
          cnt_q  <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/dac_chan.sv
module dac_chan #(
  parameter int CODE_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              srst_i,
  input  logic              wr_in_i,
  input  logic              upd_i,
  input  logic              ld_i,
  input  logic              pd_we_i,
  input  logic              pd_i,
  input  logic [CODE_W-1:0] code_i,
  output logic [CODE_W-1:0] dac_o,
  output logic              pd_o
);
  logic [CODE_W-1:0] in_q;
  logic [CODE_W-1:0] in_nxt;
  logic              pend_q;

  assign in_nxt = wr_in_i ? code_i : in_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_q   <= '0;
      dac_o  <= '0;
      pend_q <= 1'b0;
      pd_o   <= 1'b0;
    end else if (clr_i || srst_i) begin
      in_q   <= '0;
      dac_o  <= '0;
      pend_q <= 1'b0;
      if (srst_i) pd_o <= 1'b0;
    end else begin
      in_q <= in_nxt;
      if (upd_i) begin
        dac_o  <= in_nxt;
        pend_q <= 1'b0;
      end else if (wr_in_i) begin
        pend_q <= 1'b1;
      end else if (ld_i && pend_q) begin
        dac_o  <= in_q;
        pend_q <= 1'b0;
      end
      if (pd_we_i) pd_o <= pd_i;
    end
  end
endmodule

// File: rtl/dac_ctrl.sv
module dac_ctrl
  import dac_pkg::*;
#(
  parameter int CODE_W = dac_pkg::CODE_W,
  parameter int NCH    = dac_pkg::NCH
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  sclk_i,
  input  logic                  fs_ni,
  input  logic                  sdi_i,
  input  logic                  load_ni,
  input  logic                  clr_ni,
  output logic [NCH*CODE_W-1:0] dac_code_o,
  output logic [NCH-1:0]        pd_o
);
  logic               frm_vld;
  logic [FRAME_W-1:0] frm_word;
  logic               clr_q;
  logic               clr_evt;
  logic               act;
  logic               ld;
  cmd_e               cmd;
  logic [2:0]         addr;
  logic [CODE_W-1:0]  code;
  logic               unused_bits;

  assign unused_bits = ^{frm_word[FRAME_W-1:CMD_MSB+1], frm_word[CODE_LSB-1:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) clr_q <= 1'b1;
    else         clr_q <= clr_ni;
  end

  assign clr_evt = clr_q & ~clr_ni;

  dac_serial_rx #(.FRAME_W(FRAME_W)) u_rx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sclk_i (sclk_i),
    .fs_ni  (fs_ni),
    .sdi_i  (sdi_i),
    .abort_i(clr_evt),
    .vld_o  (frm_vld),
    .word_o (frm_word)
  );

  assign cmd  = cmd_e'(frm_word[CMD_MSB -: 3]);
  assign addr = frm_word[ADR_MSB -: 3];
  assign code = frm_word[CODE_LSB +: CODE_W];
  assign act  = frm_vld & ~clr_evt;
  assign ld   = ~load_ni & clr_ni & ~frm_vld;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    logic sel, wr_in, upd;
    assign sel   = (addr == 3'(ch)) || (addr == ADDR_ALL);
    assign wr_in = act & sel & ((cmd == CMD_WR_IN) || (cmd == CMD_WR_UPD_ALL) ||
                                (cmd == CMD_WR_UPD));
    assign upd   = act & ((sel & ((cmd == CMD_UPD) || (cmd == CMD_WR_UPD))) ||
                          (cmd == CMD_WR_UPD_ALL));

    dac_chan #(.CODE_W(CODE_W)) u_chan (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (clr_evt),
      .srst_i (act && (cmd == CMD_SRST)),
      .wr_in_i(wr_in),
      .upd_i  (upd),
      .ld_i   (ld),
      .pd_we_i(act && (cmd == CMD_PWR_DN)),
      .pd_i   (code[2*ch +: 2] != 2'b00),
      .code_i (code),
      .dac_o  (dac_code_o[ch*CODE_W +: CODE_W]),
      .pd_o   (pd_o[ch])
    );
  end
endmodule

// File: rtl/dac_ctrl_chk.sv
module dac_ctrl_chk #(
  parameter int CODE_W = 12,
  parameter int NCH    = 2
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  load_ni,
  input logic                  clr_ni,
  input logic                  clr_q_i,
  input logic                  frm_vld_i,
  input logic [NCH*CODE_W-1:0] dac_code_i,
  input logic [NCH-1:0]        pd_i
);
  // R9: clear edge empties the live codes
  a_r9_clear_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_q_i && !clr_ni) |=> (dac_code_i == '0));

  // R4: with no frame, no load and no clear edge, codes hold
  a_r4_codes_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!frm_vld_i && load_ni && !(clr_q_i && !clr_ni)) |=> $stable(dac_code_i));

  // R10: clear held low blocks the load strobe
  a_r10_clr_blocks_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_ni && !clr_q_i && !frm_vld_i) |=> $stable(dac_code_i));

  // R7: power-down flags move only on a completed frame
  a_r7_pd_frame_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frm_vld_i |=> $stable(pd_i));

  // R2: frame completion is a single-cycle pulse
  a_r2_vld_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frm_vld_i |=> !frm_vld_i);
endmodule

bind dac_ctrl dac_ctrl_chk #(.CODE_W(CODE_W), .NCH(NCH)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .load_ni   (load_ni),
  .clr_ni    (clr_ni),
  .clr_q_i   (clr_q),
  .frm_vld_i (frm_vld),
  .dac_code_i(dac_code_o),
  .pd_i      (pd_o)
);

// File: tb/sim_dac_ctrl.sv
module sim_dac_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 12;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic sclk = 1'b1, fs_n = 1'b1, sdi = 1'b0, load_n = 1'b1, clr_n = 1'b1;
  logic [2*CW-1:0] dac;
  logic [1:0]      pd;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dac_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_ni), .sclk_i(sclk), .fs_ni(fs_n), .sdi_i(sdi),
    .load_ni(load_n), .clr_ni(clr_n), .dac_code_o(dac), .pd_o(pd)
  );

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] frm(input logic [2:0] c, input logic [2:0] a,
                                      input logic [11:0] v);
    return {2'b00, c, a, v, 4'b0000};
  endfunction

  function automatic logic [11:0] ch_code(input int ch);
    return dac[ch*CW +: CW];
  endfunction

  task automatic bit_out(input logic b);
    sdi = b; sclk = 1'b0; wait_clk(2);
    sclk = 1'b1; wait_clk(2);
  endtask

  task automatic open_f();
    fs_n = 1'b0; wait_clk(2);
  endtask

  task automatic close_f();
    wait_clk(2); fs_n = 1'b1; wait_clk(3);
  endtask

  task automatic send_bits(input logic [23:0] w, input int first, input int n);
    for (int i = 0; i < n; i++) bit_out((first - i) >= 0 ? w[first - i] : 1'b1);
  endtask

  task automatic send(input logic [2:0] c, input logic [2:0] a, input logic [11:0] v);
    open_f(); send_bits(frm(c, a, v), 23, 24); close_f();
  endtask

  task automatic pulse_load();
    load_n = 1'b0; wait_clk(2); load_n = 1'b1; wait_clk(3);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [11:0] exp_c [2];
    exp_c[0] = '0; exp_c[1] = '0;
    wait_clk(3); rst_ni = 1'b1; wait_clk(2);

    // R1 reset state
    chk("R1 dac", dac, 0);
    chk("R1 pd", pd, 0);

    // R2 sweep: write+update per channel, other channel must hold
    for (int ch = 0; ch < 2; ch++) begin
      for (int k = 0; k < 32; k++) begin
        logic [11:0] v;
        v = (k == 0) ? 12'h000 : (k == 31) ? 12'hFFF : 12'((k * 397 + ch * 1111 + 5) % 4096);
        send(3'd3, 3'(ch), v);
        exp_c[ch] = v;
        chk("R2 sweep sel", ch_code(ch), exp_c[ch]);
        chk("R2 sweep other", ch_code(1 - ch), exp_c[1 - ch]);
      end
    end

    // R4 staged write, R5 load strobe
    send(3'd0, 3'd0, 12'h123);
    chk("R4 A held", ch_code(0), 12'hFFF);
    send(3'd0, 3'd1, 12'h456);
    chk("R4 B held", ch_code(1), 12'hFFF);
    pulse_load();
    chk("R5 A loaded", ch_code(0), 12'h123);
    chk("R5 B loaded", ch_code(1), 12'h456);
    load_n = 1'b0; wait_clk(2);
    send(3'd0, 3'd0, 12'hABC);
    chk("R5 follow", ch_code(0), 12'hABC);
    load_n = 1'b1; wait_clk(3);

    // R6 update / write-update-all / broadcast
    send(3'd0, 3'd1, 12'h321);
    send(3'd1, 3'd1, 12'h000);
    chk("R6 upd B", ch_code(1), 12'h321);
    chk("R6 upd A hold", ch_code(0), 12'hABC);
    send(3'd0, 3'd1, 12'h999);
    send(3'd2, 3'd0, 12'h0F0);
    chk("R6 all A", ch_code(0), 12'h0F0);
    chk("R6 all B", ch_code(1), 12'h999);
    send(3'd3, 3'd7, 12'h555);
    chk("R6 bcast", dac, 24'h555555);

    // R3 early release
    open_f(); send_bits(frm(3'd3, 3'd0, 12'hFFF), 23, 20); close_f();
    chk("R3 abort", ch_code(0), 12'h555);
    send(3'd3, 3'd0, 12'h246);
    chk("R3 restart", ch_code(0), 12'h246);

    // R12 extra edges, dead address, dead commands
    open_f(); send_bits(frm(3'd3, 3'd1, 12'h234), 23, 28); close_f();
    chk("R12 extra", ch_code(1), 12'h234);
    send(3'd3, 3'd3, 12'h777);
    send(3'd6, 3'd7, 12'h111);
    send(3'd7, 3'd7, 12'h222);
    chk("R12 no-op", dac, {12'h234, 12'h246});
    chk("R12 no-op pd", pd, 0);

    // R7 power-down
    send(3'd4, 3'd7, 12'h001);
    chk("R7 pd A", pd, 2'b01);
    chk("R7 codes", dac, {12'h234, 12'h246});
    send(3'd4, 3'd7, 12'h00C);
    chk("R7 pd B", pd, 2'b10);
    send(3'd4, 3'd7, 12'h00F);
    chk("R7 pd both", pd, 2'b11);

    // R9 clear, R10 load blocked while low
    clr_n = 1'b0; wait_clk(3);
    chk("R9 clr codes", dac, 0);
    chk("R9 pd kept", pd, 2'b11);
    send(3'd0, 3'd0, 12'h444);
    pulse_load();
    chk("R10 blocked", ch_code(0), 12'h000);
    clr_n = 1'b1; wait_clk(2);
    pulse_load();
    chk("R10 resumed", ch_code(0), 12'h444);
    send(3'd0, 3'd1, 12'h888);
    clr_n = 1'b0; wait_clk(2); clr_n = 1'b1; wait_clk(2);
    pulse_load();
    chk("R9 no pending", dac, 0);

    // R11 clear mid-frame
    send(3'd3, 3'd0, 12'h135);
    open_f();
    send_bits(frm(3'd3, 3'd0, 12'h777), 23, 12);
    clr_n = 1'b0; wait_clk(2); clr_n = 1'b1; wait_clk(2);
    send_bits(frm(3'd3, 3'd0, 12'h777), 11, 12);
    close_f();
    chk("R11 aborted", ch_code(0), 12'h000);
    send(3'd3, 3'd0, 12'h0AB);
    chk("R11 next ok", ch_code(0), 12'h0AB);

    // R8 software reset
    send(3'd3, 3'd1, 12'hDEF);
    send(3'd5, 3'd0, 12'h000);
    chk("R8 codes", dac, 0);
    chk("R8 pd", pd, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule